// File: doc/BRIEF.md
# Split Long-Branch Pair Executor

This block carries out the two-step call sequence that a compact 16-bit instruction stream uses to reach a distant subroutine. The signed branch offset is too wide for one halfword. It is therefore split in two. A leading halfword (the prefix) adds the high part of the offset to its own read-PC value and parks the sum in the link register. A trailing halfword (the suffix) adds the low part to that parked value and redirects the program counter. One suffix variant stays in compact state. The other forces the target onto a word boundary and leaves compact state for the 32-bit instruction state.

Each executed halfword is presented for one cycle with its address and the current link register value. One cycle later the block presents the new link value, the branch target, a one-cycle branch strobe, the instruction-state flag, an undefined-instruction flag and a sequence-error flag. A registered record of the last prefix lets the block report a prefix and suffix that are not paired.

Top module: `split_branch_exec`

## Requirements
- R1: While and after reset, `lr_out` and `pc_target` are zero, `lr_wr`, `branch_taken`, `undef_instr` and `seq_err` are low, and `t_state` is 1 (compact state).
- R2: A prefix step applies when `step_instr[15:13]` is 111 and `step_instr[12:11]` is 10. The next cycle shows `lr_out` = `step_addr` + 4 + (sign-extended `step_instr[10:0]` shifted left by 12), with `lr_wr` high, `branch_taken` low and `pc_target` held.
- R3: A same-state suffix applies when `step_instr[15:13]` is 111 and `step_instr[12:11]` is 11. The next cycle shows `pc_target` = `lr_in` + (`step_instr[10:0]` shifted left by 1), with `branch_taken` high for exactly one cycle. It also shows `lr_out` = (`step_addr` + 2) with bit 0 set and `lr_wr` high, and `t_state` unchanged.
- R4: A switching suffix applies when `step_instr[15:13]` is 111, `step_instr[12:11]` is 01 and `step_instr[0]` is 0. The next cycle shows `pc_target` = (`lr_in` + offset shifted left by 1) with bits 1:0 cleared, `lr_out` = (`step_addr` + 2) with bit 0 set, `branch_taken` and `lr_wr` high, and `t_state` 0.
- R5: A switching suffix with `step_instr[0]` = 1 raises `undef_instr` for one cycle. It writes no link value and takes no branch, so `lr_out`, `pc_target` and `t_state` keep their values.
- R6: A suffix step with no pending prefix raises `seq_err` for one cycle. The branch is still carried out.
- R7: A valid step that is not a suffix raises `seq_err` while a prefix is pending. Such a step is a second prefix, a halfword with `step_instr[12:11]` = 00, or any halfword whose bits 15:13 are not 111. Any non-prefix step clears the pending prefix, and a prefix arms it again.
- R8: A suffix raises `seq_err` when its address is not the pending prefix's address plus 2, even though a prefix is pending.
- R9: A valid step outside the prefix and suffix forms writes no link value, takes no branch and leaves `lr_out`, `pc_target` and `t_state` unchanged.
- R10: A cycle with `step_valid` low produces no pulse on any strobe, holds every output, and keeps a pending prefix pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| step_valid | input | 1 | An executed halfword is presented this cycle |
| step_instr | input | 16 | The halfword being executed |
| step_addr | input | 32 | Address of the halfword |
| lr_in | input | 32 | Current link register value |
| lr_out | output | 32 | Link register value last produced |
| lr_wr | output | 1 | One-cycle strobe: `lr_out` was written by the previous step |
| pc_target | output | 32 | Branch target last produced |
| branch_taken | output | 1 | One-cycle strobe: redirect fetch to `pc_target` |
| t_state | output | 1 | Instruction-state flag, 1 for compact state |
| undef_instr | output | 1 | One-cycle strobe: the previous step was undefined |
| seq_err | output | 1 | One-cycle strobe: the previous step broke prefix/suffix pairing |

## Verification
The pairing check and the executing units judge the same step independently, so a sequence error can land in the same cycle as a branch strobe or as an undefined flag. The bench provokes the first case with an orphan suffix and with a suffix at the wrong address. It provokes the second case with an orphan switching suffix whose low bit is set. In each case the scoreboard expects both strobes together in the cycle after the step, with link, target and state either updated or held as the step's own form requires.

// File: rtl/lbr_pkg.sv
package lbr_pkg;

    localparam int ADDR_W     = 32;
    localparam int INSN_W     = 16;
    localparam int OFF_W      = 11;
    localparam int HI_SHIFT   = OFF_W + 1;
    localparam int INSN_BYTES = INSN_W / 8;
    localparam int READ_AHEAD = 2 * INSN_BYTES;

    localparam logic [2:0] FAMILY_CODE = 3'b111;
    localparam logic [1:0] H_PREFIX    = 2'b10;
    localparam logic [1:0] H_STAY      = 2'b11;
    localparam logic [1:0] H_SWITCH    = 2'b01;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        ROLE_OTHER,
        ROLE_PREFIX,
        ROLE_STAY,
        ROLE_SWITCH
    } role_e;

    typedef struct packed {
        role_e            role;
        logic [OFF_W-1:0] off;
        logic             low_bit;
    } decoded_t;

    typedef struct packed {
        addr_t lr_val;
        logic  lr_we;
        addr_t pc_val;
        logic  taken;
        logic  t_clear;
        logic  undef;
    } result_t;

    function automatic addr_t prefix_link(input addr_t addr, input logic [OFF_W-1:0] off);
        addr_t ext;
        ext = {{(ADDR_W-OFF_W){off[OFF_W-1]}}, off};
        return addr + addr_t'(READ_AHEAD) + (ext << HI_SHIFT);
    endfunction

    function automatic addr_t suffix_sum(input addr_t lr, input logic [OFF_W-1:0] off);
        return lr + {{(ADDR_W-OFF_W-1){1'b0}}, off, 1'b0};
    endfunction

    function automatic addr_t return_link(input addr_t addr);
        return (addr + addr_t'(INSN_BYTES)) | addr_t'(1);
    endfunction

    function automatic addr_t word_align(input addr_t a);
        return a & {{(ADDR_W-2){1'b1}}, 2'b00};
    endfunction

endpackage

// File: rtl/lbr_decode.sv
module lbr_decode
    import lbr_pkg::*;
(
    input  logic [INSN_W-1:0] instr,
    output decoded_t          dec
);
    logic [2:0] family;
    logic [1:0] h_field;

    assign family  = instr[15:13];
    assign h_field = instr[12:11];

    always_comb begin
        dec.off     = instr[OFF_W-1:0];
        dec.low_bit = instr[0];
        dec.role    = ROLE_OTHER;
        if (family == FAMILY_CODE) begin
            unique case (h_field)
                H_PREFIX: dec.role = ROLE_PREFIX;
                H_STAY:   dec.role = ROLE_STAY;
                H_SWITCH: dec.role = ROLE_SWITCH;
                default:  dec.role = ROLE_OTHER;
            endcase
        end
    end
endmodule

// File: rtl/lbr_datapath.sv
module lbr_datapath
    import lbr_pkg::*;
(
    input  decoded_t dec,
    input  addr_t    addr,
    input  addr_t    lr_in,
    output result_t  res
);
    addr_t sum;

    assign sum = suffix_sum(lr_in, dec.off);

    always_comb begin
        res = '0;
        unique case (dec.role)
            ROLE_PREFIX: begin
                res.lr_val = prefix_link(addr, dec.off);
                res.lr_we  = 1'b1;
            end
            ROLE_STAY: begin
                res.lr_val = return_link(addr);
                res.lr_we  = 1'b1;
                res.pc_val = sum;
                res.taken  = 1'b1;
            end
            ROLE_SWITCH: begin
                if (dec.low_bit) begin
                    res.undef = 1'b1;
                end else begin
                    res.lr_val  = return_link(addr);
                    res.lr_we   = 1'b1;
                    res.pc_val  = word_align(sum);
                    res.taken   = 1'b1;
                    res.t_clear = 1'b1;
                end
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/lbr_sequencer.sv
module lbr_sequencer
    import lbr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  valid,
    input  role_e role,
    input  addr_t addr,
    output logic  pair_err
);
    logic  pend_q;
    addr_t paddr_q;
    logic  is_suffix;

    assign is_suffix = (role == ROLE_STAY) || (role == ROLE_SWITCH);

    always_comb begin
        pair_err = 1'b0;
        if (valid) begin
            if (is_suffix)
                pair_err = !pend_q || (addr != paddr_q + addr_t'(INSN_BYTES));
            else
                pair_err = pend_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            paddr_q <= '0;
        end else if (valid) begin
            pend_q <= (role == ROLE_PREFIX);
            if (role == ROLE_PREFIX)
                paddr_q <= addr;
        end
    end

    AST_PREFIX_THEN_OTHER: assert property (@(posedge clk) disable iff (rst)
        (valid && role == ROLE_PREFIX) ##1 (valid && !is_suffix) |-> pair_err); // R7

    AST_IDLE_KEEPS_PENDING: assert property (@(posedge clk) disable iff (rst)
        (!valid && pend_q) |=> pend_q); // R10

    AST_ORPHAN_AFTER_SUFFIX: assert property (@(posedge clk) disable iff (rst)
        (valid && is_suffix) ##1 (valid && is_suffix) |-> pair_err); // R6
endmodule

// File: rtl/split_branch_exec.sv
module split_branch_exec
    import lbr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 step_valid,
    input  logic [INSN_W-1:0]    step_instr,
    input  logic [ADDR_W-1:0]    step_addr,
    input  logic [ADDR_W-1:0]    lr_in,
    output logic [ADDR_W-1:0]    lr_out,
    output logic                 lr_wr,
    output logic [ADDR_W-1:0]    pc_target,
    output logic                 branch_taken,
    output logic                 t_state,
    output logic                 undef_instr,
    output logic                 seq_err
);
    decoded_t dec;
    result_t  res;
    logic     pair_err;

    lbr_decode u_decode (
        .instr (step_instr),
        .dec   (dec)
    );

    lbr_datapath u_datapath (
        .dec   (dec),
        .addr  (step_addr),
        .lr_in (lr_in),
        .res   (res)
    );

    lbr_sequencer u_sequencer (
        .clk      (clk),
        .rst      (rst),
        .valid    (step_valid),
        .role     (dec.role),
        .addr     (step_addr),
        .pair_err (pair_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lr_out       <= '0;
            pc_target    <= '0;
            lr_wr        <= 1'b0;
            branch_taken <= 1'b0;
            t_state      <= 1'b1;
            undef_instr  <= 1'b0;
            seq_err      <= 1'b0;
        end else begin
            lr_wr        <= step_valid && res.lr_we;
            branch_taken <= step_valid && res.taken;
            undef_instr  <= step_valid && res.undef;
            seq_err      <= step_valid && pair_err;
            if (step_valid && res.lr_we)
                lr_out <= res.lr_val;
            if (step_valid && res.taken)
                pc_target <= res.pc_val;
            if (step_valid && res.t_clear)
                t_state <= 1'b0;
        end
    end

    AST_TAKEN_NEEDS_SUFFIX: assert property (@(posedge clk) disable iff (rst)
        branch_taken |-> ($past(step_valid) && $past(step_instr[15:13]) == FAMILY_CODE
                          && $past(step_instr[12:11]) != H_PREFIX)); // R3

    AST_SWITCH_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        $past(step_valid && step_instr[15:11] == {FAMILY_CODE, H_SWITCH} && !step_instr[0])
        |-> (pc_target[1:0] == 2'b00 && !t_state && branch_taken)); // R4

    AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (rst)
        undef_instr |-> (!branch_taken && !lr_wr && $stable(lr_out) && $stable(pc_target))); // R5

    AST_LINK_ODD: assert property (@(posedge clk) disable iff (rst)
        branch_taken |-> (lr_wr && lr_out[0])); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !$past(step_valid) |-> (!branch_taken && !lr_wr && !undef_instr && !seq_err)); // R10

    AST_T_ONLY_FALLS: assert property (@(posedge clk) disable iff (rst)
        !$rose(t_state)); // R9
endmodule

// File: tb/split_branch_exec_test.sv
module split_branch_exec_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_valid = 1'b0;
    logic [15:0] step_instr = '0;
    logic [31:0] step_addr = '0;
    logic [31:0] lr_in = '0;
    logic [31:0] lr_out, pc_target;
    logic        lr_wr, branch_taken, t_state, undef_instr, seq_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    split_branch_exec uut (
        .clk(clk), .rst(rst), .step_valid(step_valid), .step_instr(step_instr),
        .step_addr(step_addr), .lr_in(lr_in), .lr_out(lr_out), .lr_wr(lr_wr),
        .pc_target(pc_target), .branch_taken(branch_taken), .t_state(t_state),
        .undef_instr(undef_instr), .seq_err(seq_err)
    );

    typedef struct {
        string       req;
        logic [31:0] lr, pc;
        logic        lrw, br, t, ud, se;
    } exp_t;

    exp_t sb[$];

    logic [31:0] m_lr = '0, m_pc = '0, m_paddr = '0;
    logic        m_t = 1'b1, m_pend = 1'b0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_lr = '0; m_pc = '0; m_paddr = '0; m_t = 1'b1; m_pend = 1'b0;
    endtask

    task automatic drive(input logic v, input logic [15:0] ins, input logic [31:0] a,
                         input logic [31:0] lri, input string req);
        exp_t        e;
        logic [10:0] off;
        logic [1:0]  h;
        logic        fam;
        logic [31:0] tgt;
        @(negedge clk);
        step_valid = v; step_instr = ins; step_addr = a; lr_in = lri;
        off = ins[10:0]; h = ins[12:11]; fam = (ins[15:13] == 3'b111);
        e.req = req; e.lrw = 0; e.br = 0; e.ud = 0; e.se = 0;
        if (v) begin
            if (fam && h == 2'b10) begin
                m_lr  = a + 32'd4 + ({{21{off[10]}}, off} << 12);
                e.lrw = 1; e.se = m_pend; m_pend = 1; m_paddr = a;
            end else if (fam && (h == 2'b11 || h == 2'b01)) begin
                e.se = !m_pend || (a != m_paddr + 32'd2);
                m_pend = 0;
                if (h == 2'b01 && ins[0]) begin
                    e.ud = 1;
                end else begin
                    tgt = lri + {20'd0, off, 1'b0};
                    if (h == 2'b01) begin
                        tgt = {tgt[31:2], 2'b00};
                        m_t = 0;
                    end
                    m_pc = tgt; m_lr = (a + 32'd2) | 32'd1;
                    e.lrw = 1; e.br = 1;
                end
            end else begin
                e.se = m_pend; m_pend = 0;
            end
        end
        e.lr = m_lr; e.pc = m_pc; e.t = m_t;
        sb.push_back(e);
    endtask

    task automatic idle(input string req);
        drive(1'b0, 16'h0000, 32'h0, 32'h0, req);
    endtask

    function automatic logic [15:0] enc(input logic [1:0] h, input logic [10:0] off);
        return {3'b111, h, off};
    endfunction

    always begin
        exp_t e;
        @(posedge clk);
        #(CLK_P/4);
        if (sb.size() > 0) begin
            e = sb.pop_front();
            chk(e.req, "lr_out", lr_out, e.lr);
            chk(e.req, "pc_target", pc_target, e.pc);
            chk(e.req, "lr_wr", {31'd0, lr_wr}, {31'd0, e.lrw});
            chk(e.req, "branch_taken", {31'd0, branch_taken}, {31'd0, e.br});
            chk(e.req, "t_state", {31'd0, t_state}, {31'd0, e.t});
            chk(e.req, "undef_instr", {31'd0, undef_instr}, {31'd0, e.ud});
            chk(e.req, "seq_err", {31'd0, seq_err}, {31'd0, e.se});
        end
    end

    task automatic check_reset_state();
        @(negedge clk);
        chk("R1", "lr_out", lr_out, 32'd0);
        chk("R1", "pc_target", pc_target, 32'd0);
        chk("R1", "t_state", {31'd0, t_state}, 32'd1);
        chk("R1", "strobes", {28'd0, lr_wr, branch_taken, undef_instr, seq_err}, 32'd0);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state();                                   // R1
        rst = 1'b0;

        // R2 then R3: positive pair
        drive(1, enc(2'b10, 11'h001), 32'h0000_1000, 32'h0, "R2");
        drive(1, enc(2'b11, 11'h010), 32'h0000_1002, 32'h0000_2004, "R3");
        idle("R10");
        // R2 negative high part then R4 with misaligned sum
        drive(1, enc(2'b10, 11'h7FF), 32'h0000_8000, 32'h0, "R2");
        drive(1, enc(2'b01, 11'h002), 32'h0000_8002, 32'h0000_7006, "R4");
        // R3 with extreme offsets, T stays 0 after switch
        drive(1, enc(2'b10, 11'h3FF), 32'h0010_0000, 32'h0, "R2");
        drive(1, enc(2'b11, 11'h7FF), 32'h0010_0002, 32'h0050_0002, "R3");
        // R5: undefined switching suffix
        drive(1, enc(2'b10, 11'h400), 32'h0040_0000, 32'h0, "R2");
        drive(1, enc(2'b01, 11'h005), 32'h0040_0002, 32'h1234_5679, "R5");
        idle("R5");
        // R6: orphan suffix still branches
        drive(1, enc(2'b11, 11'h020), 32'h0000_3000, 32'h0000_4000, "R6");
        // R7: prefix followed by prefix, then valid suffix
        drive(1, enc(2'b10, 11'h002), 32'h0000_5000, 32'h0, "R7");
        drive(1, enc(2'b10, 11'h003), 32'h0000_5002, 32'h0, "R7");
        drive(1, enc(2'b11, 11'h001), 32'h0000_5004, 32'h0000_8008, "R7");
        // R7/R9: prefix then H=00 form, then non-family halfword
        drive(1, enc(2'b10, 11'h001), 32'h0000_6000, 32'h0, "R7");
        drive(1, enc(2'b00, 11'h055), 32'h0000_6002, 32'h0, "R9");
        drive(1, enc(2'b10, 11'h001), 32'h0000_6100, 32'h0, "R7");
        drive(1, 16'h4770, 32'h0000_6102, 32'hFFFF_FFFF, "R9");
        drive(1, 16'h4770, 32'h0000_6104, 32'h0, "R9");
        // R8: suffix at wrong address
        drive(1, enc(2'b10, 11'h000), 32'h0000_0100, 32'h0, "R8");
        drive(1, enc(2'b11, 11'h004), 32'h0000_0200, 32'h0000_0104, "R8");
        // R10: idle gap keeps prefix pending
        drive(1, enc(2'b10, 11'h010), 32'h0000_9000, 32'h0, "R10");
        idle("R10");
        drive(0, enc(2'b11, 11'h0FF), 32'h0000_9002, 32'h0, "R10");
        drive(1, enc(2'b11, 11'h008), 32'h0000_9002, 32'h0001_9004, "R10");
        // R5+R6: orphan undefined switching suffix
        drive(1, enc(2'b01, 11'h003), 32'h0000_A000, 32'h0, "R6");
        idle("R10");
        idle("R10");
        repeat (3) @(negedge clk);

        // R1 again: reset mid-run restores compact state
        rst = 1'b1;
        model_reset();
        repeat (2) @(negedge clk);
        check_reset_state();                                   // R1
        rst = 1'b0;
        drive(1, enc(2'b11, 11'h001), 32'h0000_0010, 32'h0000_0020, "R6");
        idle("R3");
        repeat (3) @(negedge clk);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule